// File: doc/BRIEF.md
# Register-Write Replay Engine

The engine holds a short list of register writes in memory and plays it back onto an internal register bus whenever its trigger fires. Each list entry (a descriptor) is a pair of 32-bit words: the target register address, then the value to put there. Software sets the byte address of the first descriptor and the byte address of the last byte of the list. It then picks a trigger source and arms the channel. On each trigger the engine fetches the descriptors one word at a time, in memory order, and issues one register write for each. When the last write has been accepted it raises a sticky completion interrupt.

The expected use is to stage display-pipeline register updates during a frame, so that they are applied together at the next vertical-sync edge. A manual kick and a second event input (for example a line-count match) are also offered as trigger sources. A soft reset aborts any run and disarms the channel.

Top module: `regwr_replay_dma`

## Requirements
- R1: Descriptor k occupies bytes start+8k to start+8k+7. The word at start+8k is the register address and the word at start+8k+4 is the data. Each descriptor produces one write of that data to that address on the register bus.
- R2: Writes are issued strictly in memory order, exactly one for each descriptor in range, and never any other write.
- R3: The end register holds the inclusive last byte address. The descriptor count is floor((end − start + 1) / 8), and a trailing partial descriptor is neither fetched nor written.
- R4: If end < start, or the range holds fewer than 8 bytes, a trigger sets the done interrupt at once and issues no register write.
- R5: The trigger select field is MODE bits [1:0]. 0 = stop (nothing fires), 1 = rising edge of `vsync`, 2 = a kick written to CTRL bit 2, 3 = rising edge of `line_evt`. Only the selected source can start a run.
- R6: A vsync-armed channel runs the list once per rising edge. An edge that arrives while a run is in progress is ignored.
- R7: A register write holds `rb_valid`, `rb_addr` and `rb_data` stable until `rb_ready` is seen, and the engine does not move to the next descriptor before that.
- R8: The done interrupt sets when the last write is accepted and stays set until a 1 is written to CTRL bit 1. If completion and the clear fall in the same cycle, the interrupt is set.
- R9: Writing 1 to CTRL bit 0 (soft reset) aborts any run, clears the interrupt, drops both bus requests on the next cycle and sets the trigger select to stop.
- R10: With MODE bit 3 (address increment) set, descriptor 0 supplies the register address and descriptor k writes to that address + k, ignoring its own address word. With the bit clear, every descriptor's own address word is used.
- R11: MODE bit 2 is the write-direction flag. While it is 0, no trigger starts a run, and no fetch, write or interrupt follows.
- R12: A run applies at most MAX_DESC (default 512) descriptors, even when the programmed range is longer.
- R13: A memory read holds `mem_req` and `mem_addr` until `mem_rvalid` returns the word, with one read outstanding at a time.
- R14: After reset no request is active, the interrupt is low and the trigger select is stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 2 | Register select: 0 start, 1 end, 2 mode, 3 control |
| cfg_wdata | input | DW | Control write data |
| vsync | input | 1 | Vertical-sync event input |
| line_evt | input | 1 | Secondary event input |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data word |
| rb_valid | output | 1 | Register write valid |
| rb_addr | output | RAW | Register write address |
| rb_data | output | DW | Register write data |
| rb_ready | input | 1 | Register write accepted |
| irq_done | output | 1 | Sticky list-complete interrupt |

## Verification
The completion of a run and a software interrupt clear can land in the same cycle. If the clear were given priority, the completion of that run would be lost. The bench holds the bus ready low so that it controls which cycle the final write is accepted in. It raises ready and writes the clear bit together, so both take effect on the same edge, and then expects the interrupt to read as set. A second pairing, a vsync edge arriving during a stalled run, is judged by the exact write count and by no repeat run following.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

    localparam int DESC_BYTES = 8;
    localparam int WORD_BYTES = 4;

    localparam logic [1:0] REG_START = 2'd0;
    localparam logic [1:0] REG_END   = 2'd1;
    localparam logic [1:0] REG_MODE  = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    localparam int CTRL_SRST_BIT = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_KICK_BIT = 2;

    localparam int N_EVT     = 2;
    localparam int EVT_VSYNC = 0;
    localparam int EVT_LINE  = 1;

    typedef enum logic [1:0] {
        TRIG_STOP  = 2'd0,
        TRIG_VSYNC = 2'd1,
        TRIG_KICK  = 2'd2,
        TRIG_LINE  = 2'd3
    } trig_sel_e;

    typedef struct packed {
        logic      addr_inc;
        logic      wr_dir;
        trig_sel_e trig;
    } mode_t;

    typedef struct packed {
        logic srst;
        logic irq_clr;
        logic kick;
    } ctrl_pulse_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_DATA,
        ST_WRITE
    } seq_state_e;

    function automatic mode_t mode_idle();
        mode_t m;
        m.addr_inc = 1'b0;
        m.wr_dir   = 1'b0;
        m.trig     = TRIG_STOP;
        return m;
    endfunction

endpackage

// File: rtl/regwr_cfg.sv
module regwr_cfg
    import regwr_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [AW-1:0] start_o,
    output logic [AW-1:0] end_o,
    output mode_t         mode_o,
    output ctrl_pulse_t   pulse_o
);

    always_comb begin
        pulse_o = '0;
        if (cfg_we && cfg_addr == REG_CTRL) begin
            pulse_o.srst    = cfg_wdata[CTRL_SRST_BIT];
            pulse_o.irq_clr = cfg_wdata[CTRL_CLR_BIT];
            pulse_o.kick    = cfg_wdata[CTRL_KICK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_o <= '0;
            end_o   <= '0;
            mode_o  <= mode_idle();
        end else begin
            if (cfg_we) begin
                case (cfg_addr)
                    REG_START: start_o <= cfg_wdata[AW-1:0];
                    REG_END:   end_o   <= cfg_wdata[AW-1:0];
                    REG_MODE:  mode_o  <= mode_t'(cfg_wdata[3:0]);
                    default:   ;
                endcase
            end
            if (pulse_o.srst) begin
                mode_o.trig <= TRIG_STOP;
            end
        end
    end

endmodule

// File: rtl/regwr_trig.sv
module regwr_trig
    import regwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             kick_i,
    input  logic             srst_i,
    input  mode_t            mode_i,
    output logic             fire_o
);

    logic [N_EVT-1:0] evt_rise;

    for (genvar g = 0; g < N_EVT; g++) begin : g_edge
        logic evt_q;
        always_ff @(posedge clk) begin
            if (rst) evt_q <= 1'b0;
            else     evt_q <= evt_i[g];
        end
        assign evt_rise[g] = evt_i[g] & ~evt_q;
    end

    logic hit;

    always_comb begin
        case (mode_i.trig)
            TRIG_VSYNC: hit = evt_rise[EVT_VSYNC];
            TRIG_KICK:  hit = kick_i;
            TRIG_LINE:  hit = evt_rise[EVT_LINE];
            default:    hit = 1'b0;
        endcase
        fire_o = hit & mode_i.wr_dir & ~srst_i;
    end

endmodule

// File: rtl/regwr_seq.sv
module regwr_seq
    import regwr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RAW      = 32,
    parameter int DW       = 32,
    parameter int MAX_DESC = 512
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           abort_i,
    input  logic           fire_i,
    input  logic           irq_clr_i,
    input  logic [AW-1:0]  start_i,
    input  logic [AW-1:0]  end_i,
    input  logic           addr_inc_i,
    output logic           mem_req_o,
    output logic [AW-1:0]  mem_addr_o,
    input  logic           mem_rvalid_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           rb_valid_o,
    output logic [RAW-1:0] rb_addr_o,
    output logic [DW-1:0]  rb_data_o,
    input  logic           rb_ready_i,
    output logic           irq_o
);

    localparam int CNT_W = $clog2(MAX_DESC + 1);
    localparam int SHIFT = $clog2(DESC_BYTES);
    localparam logic [AW:0]      MAX_N = (AW+1)'(MAX_DESC);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_DESC);

    seq_state_e       state;
    logic [AW-1:0]    ptr;
    logic [CNT_W-1:0] left;
    logic             first;
    logic             inc_q;
    logic [RAW-1:0]   cur_addr;
    logic [DW-1:0]    cur_data;

    logic [AW:0]      span;
    logic [AW:0]      n_raw;
    logic [CNT_W-1:0] n_desc;

    always_comb begin
        span  = {1'b0, end_i} - {1'b0, start_i} + (AW+1)'(1);
        n_raw = span >> SHIFT;
        if (end_i < start_i)    n_desc = '0;
        else if (n_raw > MAX_N) n_desc = MAX_C;
        else                    n_desc = n_raw[CNT_W-1:0];
    end

    logic start_run;
    logic last_ack;
    logic done_evt;

    assign start_run = (state == ST_IDLE) && fire_i;
    assign last_ack  = (state == ST_WRITE) && rb_ready_i && (left == CNT_W'(1));
    assign done_evt  = (start_run && n_desc == '0) || last_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            left     <= '0;
            first    <= 1'b0;
            inc_q    <= 1'b0;
            cur_addr <= '0;
            cur_data <= '0;
        end else if (abort_i) begin
            state <= ST_IDLE;
            left  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_run && n_desc != '0) begin
                        ptr   <= start_i;
                        left  <= n_desc;
                        first <= 1'b1;
                        inc_q <= addr_inc_i;
                        state <= ST_RD_ADDR;
                    end
                end
                ST_RD_ADDR: begin
                    if (mem_rvalid_i) begin
                        if (inc_q && !first) cur_addr <= cur_addr + RAW'(1);
                        else                 cur_addr <= mem_rdata_i[RAW-1:0];
                        ptr   <= ptr + AW'(WORD_BYTES);
                        state <= ST_RD_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (mem_rvalid_i) begin
                        cur_data <= mem_rdata_i;
                        ptr      <= ptr + AW'(WORD_BYTES);
                        state    <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (rb_ready_i) begin
                        left  <= left - CNT_W'(1);
                        first <= 1'b0;
                        state <= (left == CNT_W'(1)) ? ST_IDLE : ST_RD_ADDR;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort_i) irq_o <= 1'b0;
        else if (done_evt)  irq_o <= 1'b1;
        else if (irq_clr_i) irq_o <= 1'b0;
    end

    assign mem_req_o  = (state == ST_RD_ADDR) || (state == ST_RD_DATA);
    assign mem_addr_o = ptr;
    assign rb_valid_o = (state == ST_WRITE);
    assign rb_addr_o  = cur_addr;
    assign rb_data_o  = cur_data;

endmodule

// File: rtl/regwr_replay_dma.sv
module regwr_replay_dma
    import regwr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RAW      = 32,
    parameter int DW       = 32,
    parameter int MAX_DESC = 512
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           vsync,
    input  logic           line_evt,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    output logic           rb_valid,
    output logic [RAW-1:0] rb_addr,
    output logic [DW-1:0]  rb_data,
    input  logic           rb_ready,
    output logic           irq_done
);

    logic [AW-1:0]    start_addr;
    logic [AW-1:0]    end_addr;
    mode_t            mode;
    ctrl_pulse_t      pulse;
    logic             fire;
    logic             soft_rst;
    logic             irq_clr;
    logic [N_EVT-1:0] evt;

    assign soft_rst        = pulse.srst;
    assign irq_clr         = pulse.irq_clr;
    assign evt[EVT_VSYNC]  = vsync;
    assign evt[EVT_LINE]   = line_evt;

    regwr_cfg #(.AW(AW), .DW(DW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .start_o   (start_addr),
        .end_o     (end_addr),
        .mode_o    (mode),
        .pulse_o   (pulse)
    );

    regwr_trig u_trig (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .kick_i (pulse.kick),
        .srst_i (soft_rst),
        .mode_i (mode),
        .fire_o (fire)
    );

    regwr_seq #(.AW(AW), .RAW(RAW), .DW(DW), .MAX_DESC(MAX_DESC)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .abort_i      (soft_rst),
        .fire_i       (fire),
        .irq_clr_i    (irq_clr),
        .start_i      (start_addr),
        .end_i        (end_addr),
        .addr_inc_i   (mode.addr_inc),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .rb_valid_o   (rb_valid),
        .rb_addr_o    (rb_addr),
        .rb_data_o    (rb_data),
        .rb_ready_i   (rb_ready),
        .irq_o        (irq_done)
    );

endmodule

// File: rtl/regwr_replay_chk.sv
module regwr_replay_chk #(
    parameter int AW  = 32,
    parameter int RAW = 32,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           soft_rst,
    input logic           irq_clr,
    input logic           mem_req,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_rvalid,
    input logic           rb_valid,
    input logic [RAW-1:0] rb_addr,
    input logic [DW-1:0]  rb_data,
    input logic           rb_ready,
    input logic           irq_done
);

    // R7
    rb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rb_valid && !rb_ready && !soft_rst) |=>
            (rb_valid && $stable(rb_addr) && $stable(rb_data)));

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid && !soft_rst) |=> (mem_req && $stable(mem_addr)));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_done && !irq_clr && !soft_rst) |=> irq_done);

    // R9
    srst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!rb_valid && !mem_req && !irq_done));

    // R14
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rb_valid && !mem_req && !irq_done));

endmodule

bind regwr_replay_dma regwr_replay_chk #(.AW(AW), .RAW(RAW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .irq_clr    (irq_clr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rb_valid   (rb_valid),
    .rb_addr    (rb_addr),
    .rb_data    (rb_data),
    .rb_ready   (rb_ready),
    .irq_done   (irq_done)
);

// File: tb/tb_regwr_replay_dma.sv
module tb_regwr_replay_dma;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32, RAW = 32, DW = 32, MAX_DESC = 512;

    localparam logic [1:0] A_START = 2'd0, A_END = 2'd1, A_MODE = 2'd2, A_CTRL = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic vsync = 1'b0, line_evt = 1'b0;
    logic mem_req, mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic rb_valid, rb_ready, irq_done;
    logic [RAW-1:0] rb_addr;
    logic [DW-1:0] rb_data;

    regwr_replay_dma #(.AW(AW), .RAW(RAW), .DW(DW), .MAX_DESC(MAX_DESC)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .vsync(vsync), .line_evt(line_evt),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rb_valid(rb_valid), .rb_addr(rb_addr), .rb_data(rb_data), .rb_ready(rb_ready),
        .irq_done(irq_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_errors = 0, wr_count = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];
    logic [31:0] mem [0:2047];

    int mem_lat = 1, mem_cnt = 0;
    int rdy_mode = 0;
    logic rdy_man = 1'b0;
    logic [7:0] lfsr = 8'h5a;

    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_cnt <= 0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            mem_cnt <= 0;
        end else if (mem_req) begin
            if (mem_cnt >= mem_lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata <= mem[mem_addr[12:2]];
            end else begin
                mem_cnt <= mem_cnt + 1;
            end
        end
    end

    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    assign rb_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : rdy_man;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor (R1, R2)
    always @(negedge clk) begin
        if (!rst && rb_valid && rb_ready) begin
            wr_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected write", {rb_addr, rb_data}, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({rb_addr, rb_data} === e, "R1 write addr/data", {rb_addr, rb_data}, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Fill memory with n descriptors and push the first n_exp expected writes.
    task automatic load_list(input int base, input int n, input int n_exp, input bit inc);
        logic [31:0] a0;
        a0 = 32'h0000_1000 + base;
        for (int k = 0; k < n; k++) begin
            logic [31:0] a, d;
            a = a0 + k * 32'h13 + ((k % 2) * 32'h400);
            d = 32'hC000_0000 ^ (base << 12) ^ (k * 32'h0101_0101) ^ k;
            mem[(base / 4) + 2 * k]     = a;
            mem[(base / 4) + 2 * k + 1] = d;
            if (k < n_exp) exp_q.push_back({inc ? (a0 + k) : a, d});
        end
    endtask

    task automatic wait_irq(input string req, input int max);
        bit seen = 1'b0;
        for (int i = 0; i < max && !seen; i++) begin
            if (irq_done) seen = 1'b1;
            else tick();
        end
        check(seen, req, {63'd0, irq_done}, 64'd1);
    endtask

    task automatic wait_valid(input string req, input int max);
        bit seen = 1'b0;
        for (int i = 0; i < max && !seen; i++) begin
            if (rb_valid) seen = 1'b1;
            else tick();
        end
        check(seen, req, {63'd0, rb_valid}, 64'd1);
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    endtask

    task automatic pulse_vsync();
        vsync = 1'b1; tick(); vsync = 1'b0; tick();
    endtask

    task automatic pulse_line();
        line_evt = 1'b1; tick(); line_evt = 1'b0; tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int w;
        for (int i = 0; i < 2048; i++) mem[i] = 32'hDEAD_0000 + i;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R14 reset state
        check(!rb_valid && !mem_req && !irq_done, "R14 outputs idle after reset",
              {61'd0, rb_valid, mem_req, irq_done}, 64'd0);
        cfg_write(A_MODE, 32'h4);
        cfg_write(A_START, 32'h0); cfg_write(A_END, 32'h17);
        cfg_write(A_CTRL, 32'h4);
        repeat (10) tick();
        check(!irq_done && wr_count == 0, "R14 trigger select stop after reset", 64'(wr_count), 64'd0);

        // R1 R2 basic manual kick
        load_list(32'h000, 3, 3, 1'b0);
        cfg_write(A_START, 32'h000); cfg_write(A_END, 32'h017);
        cfg_write(A_MODE, 32'h6);
        cfg_write(A_CTRL, 32'h4);
        wait_irq("R8 done after manual run", 200);
        drained("R2 all descriptors written in order");

        // R8 sticky, then clear
        repeat (10) tick();
        check(irq_done, "R8 interrupt stays set", {63'd0, irq_done}, 64'd1);
        cfg_write(A_CTRL, 32'h2);
        check(!irq_done, "R8 clear drops interrupt", {63'd0, irq_done}, 64'd0);

        // R7 R13 random stalls and slow memory
        rdy_mode = 1; mem_lat = 3;
        load_list(32'h100, 5, 5, 1'b0);
        cfg_write(A_START, 32'h100); cfg_write(A_END, 32'h127);
        cfg_write(A_CTRL, 32'h4);
        wait_irq("R7 done under stalls", 1000);
        drained("R7 writes intact under stalls");
        rdy_mode = 0; mem_lat = 1;
        cfg_write(A_CTRL, 32'h2);

        // R3 inclusive end with a partial trailing descriptor
        w = wr_count;
        load_list(32'h200, 4, 3, 1'b0);
        cfg_write(A_START, 32'h200); cfg_write(A_END, 32'h21B);
        cfg_write(A_CTRL, 32'h4);
        wait_irq("R3 done", 300);
        repeat (10) tick();
        drained("R3 descriptors in range");
        check(wr_count - w == 3, "R3 partial descriptor skipped", 64'(wr_count - w), 64'd3);
        cfg_write(A_CTRL, 32'h2);

        // R4 end below start
        w = wr_count;
        cfg_write(A_START, 32'h300); cfg_write(A_END, 32'h2FF);
        cfg_write(A_CTRL, 32'h4);
        repeat (3) tick();
        check(irq_done, "R4 empty list completes", {63'd0, irq_done}, 64'd1);
        check(wr_count == w && !mem_req, "R4 no write on empty list", 64'(wr_count - w), 64'd0);
        cfg_write(A_CTRL, 32'h2);

        // R4 fewer than 8 bytes
        cfg_write(A_START, 32'h300); cfg_write(A_END, 32'h306);
        cfg_write(A_CTRL, 32'h4);
        repeat (3) tick();
        check(irq_done && wr_count == w, "R4 short range empty", 64'(wr_count - w), 64'd0);
        cfg_write(A_CTRL, 32'h2);

        // R5 stop select ignores every source
        load_list(32'h400, 2, 0, 1'b0);
        cfg_write(A_START, 32'h400); cfg_write(A_END, 32'h40F);
        cfg_write(A_MODE, 32'h4);
        cfg_write(A_CTRL, 32'h4);
        pulse_vsync(); pulse_line();
        repeat (20) tick();
        check(!irq_done && wr_count == w, "R5 stop select never fires", 64'(wr_count - w), 64'd0);

        // R11 direction flag clear blocks triggers
        cfg_write(A_MODE, 32'h2);
        cfg_write(A_CTRL, 32'h4);
        repeat (20) tick();
        check(!irq_done && wr_count == w && !mem_req, "R11 read direction blocks run",
              64'(wr_count - w), 64'd0);

        // R6 vsync: edge during a run ignored
        load_list(32'h500, 4, 4, 1'b0);
        cfg_write(A_START, 32'h500); cfg_write(A_END, 32'h51F);
        cfg_write(A_MODE, 32'h5);
        rdy_mode = 2; rdy_man = 1'b0;
        pulse_vsync();
        wait_valid("R6 run started on vsync", 100);
        pulse_vsync();
        rdy_mode = 0;
        wait_irq("R6 done after vsync run", 300);
        drained("R6 first vsync run");
        w = wr_count;
        repeat (30) tick();
        check(wr_count == w, "R6 edge during run ignored", 64'(wr_count - w), 64'd0);
        cfg_write(A_CTRL, 32'h2);
        load_list(32'h500, 4, 4, 1'b0);
        pulse_vsync();
        wait_irq("R6 second edge reruns", 300);
        drained("R6 second vsync run");
        cfg_write(A_CTRL, 32'h2);

        // R5 line event source
        load_list(32'h600, 2, 2, 1'b0);
        cfg_write(A_START, 32'h600); cfg_write(A_END, 32'h60F);
        cfg_write(A_MODE, 32'h7);
        pulse_line();
        wait_irq("R5 line event run", 200);
        drained("R5 line event writes");
        cfg_write(A_CTRL, 32'h2);

        // R10 address increment
        load_list(32'h700, 4, 4, 1'b1);
        cfg_write(A_START, 32'h700); cfg_write(A_END, 32'h71F);
        cfg_write(A_MODE, 32'hE);
        cfg_write(A_CTRL, 32'h4);
        wait_irq("R10 done", 300);
        drained("R10 incrementing addresses");
        cfg_write(A_CTRL, 32'h2);

        // R9 soft reset mid-run
        load_list(32'h800, 6, 0, 1'b0);
        cfg_write(A_START, 32'h800); cfg_write(A_END, 32'h82F);
        cfg_write(A_MODE, 32'h6);
        rdy_mode = 2; rdy_man = 1'b0;
        cfg_write(A_CTRL, 32'h4);
        wait_valid("R9 run in progress", 100);
        cfg_write(A_CTRL, 32'h1);
        check(!rb_valid && !mem_req && !irq_done, "R9 soft reset quiets outputs",
              {61'd0, rb_valid, mem_req, irq_done}, 64'd0);
        rdy_mode = 0;
        w = wr_count;
        repeat (20) tick();
        check(wr_count == w, "R9 aborted run writes nothing", 64'(wr_count - w), 64'd0);
        cfg_write(A_CTRL, 32'h4);
        repeat (20) tick();
        check(wr_count == w && !irq_done, "R9 select forced to stop", 64'(wr_count - w), 64'd0);

        // R12 cap at MAX_DESC
        w = wr_count;
        load_list(32'h000, 600, MAX_DESC, 1'b0);
        cfg_write(A_START, 32'h000); cfg_write(A_END, 600 * 8 - 1);
        cfg_write(A_MODE, 32'h6);
        cfg_write(A_CTRL, 32'h4);
        wait_irq("R12 done on long list", 20000);
        repeat (20) tick();
        drained("R12 capped list contents");
        check(wr_count - w == MAX_DESC, "R12 descriptor cap", 64'(wr_count - w), 64'(MAX_DESC));
        cfg_write(A_CTRL, 32'h2);

        // R8 completion and clear in the same cycle: set wins
        load_list(32'h900, 2, 2, 1'b0);
        cfg_write(A_START, 32'h900); cfg_write(A_END, 32'h90F);
        rdy_mode = 2; rdy_man = 1'b0;
        cfg_write(A_CTRL, 32'h4);
        wait_valid("R8 first write pending", 100);
        rdy_man = 1'b1; tick(); rdy_man = 1'b0;
        wait_valid("R8 last write pending", 100);
        rdy_man = 1'b1;
        cfg_we = 1'b1; cfg_addr = A_CTRL; cfg_wdata = 32'h2;
        tick();
        rdy_man = 1'b0; cfg_we = 1'b0;
        check(irq_done, "R8 completion beats same-cycle clear", {63'd0, irq_done}, 64'd1);
        drained("R8 race run writes");
        rdy_mode = 0;

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule